// File: doc/BRIEF.md
# Video Sync Output Generator

This block produces the timing strobes that travel beside a 4:2:2 pixel stream. A horizontal counter steps once per pixel clock and wraps at the line length of the selected standard. A vertical counter steps at each line wrap and splits every frame into two fields. From these two counts the block decodes a horizontal pulse, a vertical pulse, a line-reference strobe and a field flag. Each output leaves through a register, so all four outputs have the same latency.

Two pins carry either sync-style pulses or active-region windows, chosen by a 2-bit mode input. The position of the horizontal pulse is set by two 10-bit edge values. These are counted in pairs of pixel clocks, so each value is doubled before it is compared with the horizontal count. Separate inversion bits set the polarity of the horizontal pin, the vertical pin and the field flag.

With the default parameters a line lasts 858 clocks (525-line standard) or 864 clocks (625-line standard), and the line-reference strobe spans 720 clocks, one per luma sample.

Top module: `video_sync_gen`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0. The first output word after reset describes pixel 0 of line 0 of the first field.
- R2: `pal_sel`=0 selects `H_NTSC` clocks per line and `V_NTSC` lines per frame. `pal_sel`=1 selects `H_PAL` and `V_PAL`. The first field holds (lines+1)/2 lines and the second field holds the rest.
- R3: The raw horizontal pulse is high for each count h with 2*`hs_begin` <= h < 2*`hs_end`. When `hs_begin` > `hs_end`, it is high for h >= 2*`hs_begin` or h < 2*`hs_end`. When the two values are equal, it never goes high.
- R4: The raw vertical pulse is high during the first `VS_LINES` lines (default 6) of each field.
- R5: `out_mode` 2'b00 puts the pulses on `hs_o`/`vs_o`. Modes 2'b01, 2'b10 and 2'b11 all put the active windows on those pins.
- R6: The horizontal window is high on every line for h in [`HACT_START`, `HACT_START`+`ACT_LEN`). The vertical window is high on lines whose index within the field is at least `V_BLANK`.
- R7: `href_o` is high when both windows are high. This gives `ACT_LEN` clocks on each active line. It does not depend on mode or on any polarity bit.
- R8: The raw field flag is 1 while the second (even) field is scanned. It changes value at each field boundary.
- R9: `pol_h`, `pol_v` and `pol_field` set to 1 invert `hs_o`, `vs_o` and `field_o` respectively.
- R10: Every output is registered. The value seen after clock edge k (k >= 1 since reset release) describes counter position k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_sel | input | 1 | 0: 525-line timing, 1: 625-line timing |
| out_mode | input | 2 | 00 sync pulses, otherwise active windows |
| hs_begin | input | 10 | Horizontal pulse start, in units of two clocks |
| hs_end | input | 10 | Horizontal pulse end, in units of two clocks |
| pol_h | input | 1 | Invert `hs_o` |
| pol_v | input | 1 | Invert `vs_o` |
| pol_field | input | 1 | Invert `field_o` |
| hs_o | output | 1 | Horizontal pulse or horizontal window |
| vs_o | output | 1 | Vertical pulse or vertical window |
| href_o | output | 1 | Active-line reference strobe |
| field_o | output | 1 | Field flag |

## Verification
A horizontal counter that wraps at the wrong count moves every edge that follows. The error shows on `hs_o` and `href_o` within the first line, and it then shifts the vertical and field edges by whole lines. A wrong vertical count or field split appears at the first field boundary, at the latest within one frame. The bench therefore compares all four outputs on every clock over two full frames for each mode, standard and edge setting. The checker adds bounds on both counters and a limit on the length of an `href_o` run.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic [1:0] {
        OM_SYNC  = 2'b00,
        OM_ACT_A = 2'b01,
        OM_ACT_B = 2'b10,
        OM_ACT_C = 2'b11
    } omode_e;

    typedef struct packed {
        logic hs;
        logic vs;
        logic href;
        logic fld;
    } vsg_out_t;

endpackage

// File: rtl/vsg_hv_counter.sv
module vsg_hv_counter #(
    parameter int H_NTSC = 858,
    parameter int H_PAL  = 864,
    parameter int V_NTSC = 525,
    parameter int V_PAL  = 625,
    parameter int HW     = 10,
    parameter int VW     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pal_sel,
    output logic [HW-1:0] h_q,
    output logic [VW-1:0] v_q
);
    localparam logic [HW-1:0] H_LAST_N = HW'(H_NTSC - 1);
    localparam logic [HW-1:0] H_LAST_P = HW'(H_PAL - 1);
    localparam logic [VW-1:0] V_LAST_N = VW'(V_NTSC - 1);
    localparam logic [VW-1:0] V_LAST_P = VW'(V_PAL - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [HW-1:0] h_last;
    logic [VW-1:0] v_last;

    always_comb begin
        h_last = pal_sel ? H_LAST_P : H_LAST_N;
        v_last = pal_sel ? V_LAST_P : V_LAST_N;
        cnt_d  = cnt_q;
        if (cnt_q.h >= h_last) begin
            cnt_d.h = '0;
            if (cnt_q.v >= v_last) begin
                cnt_d.v = '0;
            end else begin
                cnt_d.v = cnt_q.v + 1'b1;
            end
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign h_q = cnt_q.h;
    assign v_q = cnt_q.v;
endmodule

// File: rtl/vsg_hdecode.sv
module vsg_hdecode #(
    parameter int HW         = 10,
    parameter int HACT_START = 122,
    parameter int ACT_LEN    = 720
) (
    input  logic [HW-1:0] h,
    input  logic [9:0]    hs_begin,
    input  logic [9:0]    hs_end,
    output logic          hs_raw,
    output logic          hwin_raw
);
    localparam int CW = (HW > 11) ? HW : 11;
    localparam logic [HW-1:0] HA_LO = HW'(HACT_START);
    localparam logic [HW-1:0] HA_HI = HW'(HACT_START + ACT_LEN);

    logic [CW-1:0] h_ext;
    logic [CW-1:0] b2;
    logic [CW-1:0] e2;
    logic          after_b;
    logic          before_e;

    always_comb begin
        h_ext    = CW'(h);
        b2       = CW'({hs_begin, 1'b0});
        e2       = CW'({hs_end, 1'b0});
        after_b  = (h_ext >= b2);
        before_e = (h_ext < e2);
        if (hs_begin < hs_end) begin
            hs_raw = after_b && before_e;
        end else if (hs_begin > hs_end) begin
            hs_raw = after_b || before_e;
        end else begin
            hs_raw = 1'b0;
        end
        hwin_raw = (h >= HA_LO) && (h < HA_HI);
    end
endmodule

// File: rtl/vsg_vdecode.sv
module vsg_vdecode #(
    parameter int V_NTSC   = 525,
    parameter int V_PAL    = 625,
    parameter int VS_LINES = 6,
    parameter int V_BLANK  = 20,
    parameter int VW       = 10
) (
    input  logic [VW-1:0] v,
    input  logic          pal_sel,
    output logic          vs_raw,
    output logic          vwin_raw,
    output logic          fld_raw
);
    localparam logic [VW-1:0] F0_N   = VW'((V_NTSC + 1) / 2);
    localparam logic [VW-1:0] F0_P   = VW'((V_PAL + 1) / 2);
    localparam logic [VW-1:0] VS_LEN = VW'(VS_LINES);
    localparam logic [VW-1:0] VB_LEN = VW'(V_BLANK);

    logic [VW-1:0] f0_len;
    logic [VW-1:0] line_in_field;

    always_comb begin
        f0_len        = pal_sel ? F0_P : F0_N;
        fld_raw       = (v >= f0_len);
        line_in_field = fld_raw ? (v - f0_len) : v;
        vs_raw        = (line_in_field < VS_LEN);
        vwin_raw      = (line_in_field >= VB_LEN);
    end
endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen #(
    parameter int H_NTSC     = 858,
    parameter int H_PAL      = 864,
    parameter int V_NTSC     = 525,
    parameter int V_PAL      = 625,
    parameter int HACT_START = 122,
    parameter int ACT_LEN    = 720,
    parameter int VS_LINES   = 6,
    parameter int V_BLANK    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_sel,
    input  logic [1:0] out_mode,
    input  logic [9:0] hs_begin,
    input  logic [9:0] hs_end,
    input  logic       pol_h,
    input  logic       pol_v,
    input  logic       pol_field,
    output logic       hs_o,
    output logic       vs_o,
    output logic       href_o,
    output logic       field_o
);
    import vsg_pkg::*;

    localparam int H_MAX = (H_NTSC > H_PAL) ? H_NTSC : H_PAL;
    localparam int V_MAX = (V_NTSC > V_PAL) ? V_NTSC : V_PAL;
    localparam int HW    = $clog2(H_MAX + 1);
    localparam int VW    = $clog2(V_MAX + 1);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic hs_raw, hwin_raw, vs_raw, vwin_raw, fld_raw;
    omode_e mode;
    vsg_out_t out_d, out_q;

    vsg_hv_counter #(
        .H_NTSC(H_NTSC), .H_PAL(H_PAL), .V_NTSC(V_NTSC), .V_PAL(V_PAL),
        .HW(HW), .VW(VW)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel),
        .h_q(h_cnt), .v_q(v_cnt)
    );

    vsg_hdecode #(
        .HW(HW), .HACT_START(HACT_START), .ACT_LEN(ACT_LEN)
    ) u_hdec (
        .h(h_cnt), .hs_begin(hs_begin), .hs_end(hs_end),
        .hs_raw(hs_raw), .hwin_raw(hwin_raw)
    );

    vsg_vdecode #(
        .V_NTSC(V_NTSC), .V_PAL(V_PAL), .VS_LINES(VS_LINES),
        .V_BLANK(V_BLANK), .VW(VW)
    ) u_vdec (
        .v(v_cnt), .pal_sel(pal_sel),
        .vs_raw(vs_raw), .vwin_raw(vwin_raw), .fld_raw(fld_raw)
    );

    always_comb begin
        mode = omode_e'(out_mode);
        if (mode == OM_SYNC) begin
            out_d.hs = hs_raw ^ pol_h;
            out_d.vs = vs_raw ^ pol_v;
        end else begin
            out_d.hs = hwin_raw ^ pol_h;
            out_d.vs = vwin_raw ^ pol_v;
        end
        out_d.href = hwin_raw && vwin_raw;
        out_d.fld  = fld_raw ^ pol_field;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hs_o    = out_q.hs;
    assign vs_o    = out_q.vs;
    assign href_o  = out_q.href;
    assign field_o = out_q.fld;
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
    parameter int H_NTSC  = 858,
    parameter int H_PAL   = 864,
    parameter int V_NTSC  = 525,
    parameter int V_PAL   = 625,
    parameter int ACT_LEN = 720,
    parameter int HW      = 10,
    parameter int VW      = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pal_sel,
    input logic [1:0]    out_mode,
    input logic [9:0]    hs_begin,
    input logic [9:0]    hs_end,
    input logic          pol_h,
    input logic          pol_v,
    input logic          pol_field,
    input logic          hs_o,
    input logic          vs_o,
    input logic          href_o,
    input logic          field_o,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (href_o) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(h_cnt) < (pal_sel ? H_PAL : H_NTSC)) || !$stable(pal_sel));

    // R2
    v_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(v_cnt) < (pal_sel ? V_PAL : V_NTSC)) || !$stable(pal_sel));

    // R7
    href_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(run_q) <= ACT_LEN);

    // R7
    href_in_hwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (href_o && out_mode != 2'b00 && !pol_h && $stable(out_mode) && $stable(pol_h)) |-> hs_o);

    // R3
    hs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hs_begin) == $past(hs_end) && $past(out_mode) == 2'b00)
        |-> (hs_o == $past(pol_h)));

    // R8
    field_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(field_o) && $stable(pol_field) && $stable(pol_v)
         && out_mode == 2'b00 && $stable(out_mode)) |-> (vs_o == !pol_v));
endmodule

bind video_sync_gen vsg_checker #(
    .H_NTSC(H_NTSC), .H_PAL(H_PAL), .V_NTSC(V_NTSC), .V_PAL(V_PAL),
    .ACT_LEN(ACT_LEN), .HW(HW), .VW(VW)
) u_vsg_chk (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .out_mode(out_mode),
    .hs_begin(hs_begin), .hs_end(hs_end), .pol_h(pol_h), .pol_v(pol_v),
    .pol_field(pol_field), .hs_o(hs_o), .vs_o(vs_o), .href_o(href_o),
    .field_o(field_o), .h_cnt(h_cnt), .v_cnt(v_cnt)
);

// File: tb/tb_video_sync_gen.sv
module tb_video_sync_gen;
    localparam int HN = 40, HP = 48, VN = 21, VP = 25;
    localparam int HAS = 8, ACT = 24, VSL = 6, VBL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pal_sel = 1'b0;
    logic [1:0] out_mode = 2'b00;
    logic [9:0] hs_begin = 10'd0, hs_end = 10'd0;
    logic pol_h = 1'b0, pol_v = 1'b0, pol_field = 1'b0;
    logic hs_o, vs_o, href_o, field_o;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    video_sync_gen #(
        .H_NTSC(HN), .H_PAL(HP), .V_NTSC(VN), .V_PAL(VP),
        .HACT_START(HAS), .ACT_LEN(ACT), .VS_LINES(VSL), .V_BLANK(VBL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .out_mode(out_mode),
        .hs_begin(hs_begin), .hs_end(hs_end), .pol_h(pol_h), .pol_v(pol_v),
        .pol_field(pol_field), .hs_o(hs_o), .vs_o(vs_o), .href_o(href_o),
        .field_o(field_o)
    );

    // expected {hs, vs, href, field} for counter position p
    function automatic logic [3:0] model(int p);
        int h_tot = pal_sel ? HP : HN;
        int v_tot = pal_sel ? VP : VN;
        int f0 = (v_tot + 1) / 2;
        int pos = p % (h_tot * v_tot);
        int h = pos % h_tot;
        int v = pos / h_tot;
        int hb = int'(hs_begin) * 2;
        int he = int'(hs_end) * 2;
        bit fld = (v >= f0);
        int vl = fld ? v - f0 : v;
        bit hs, hw, va, ho, vo;
        if (hs_begin < hs_end) hs = (h >= hb) && (h < he);
        else if (hs_begin > hs_end) hs = (h >= hb) || (h < he);
        else hs = 1'b0;
        hw = (h >= HAS) && (h < HAS + ACT);
        va = (vl >= VBL);
        ho = (out_mode == 2'b00) ? hs : hw;
        vo = (out_mode == 2'b00) ? (vl < VSL) : va;
        return {ho ^ pol_h, vo ^ pol_v, hw && va, fld ^ pol_field};
    endfunction

    task automatic check(string tag, string what, int nbad, logic act, logic exp);
        total++;
        if (nbad != 0) begin
            bad++;
            $display("FAIL %s %s: %0d mismatches, first actual=%0b expected=%0b",
                     tag, what, nbad, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic run_scn(string name, string th, string tv, string tr, string tf);
        int n = 2 * (pal_sel ? HP * VP : HN * VN);
        int nb[4] = '{0, 0, 0, 0};
        logic [3:0] fa = '0, fe = '0;
        bit seen[4] = '{0, 0, 0, 0};
        do_reset();
        for (int k = 1; k <= n; k++) begin
            logic [3:0] e, a;
            @(posedge clk);
            #1;
            e = model(k - 1);
            a = {hs_o, vs_o, href_o, field_o};
            for (int i = 0; i < 4; i++) begin
                if (a[i] !== e[i]) begin
                    nb[i]++;
                    if (!seen[i]) begin
                        seen[i] = 1'b1;
                        fa[i] = a[i];
                        fe[i] = e[i];
                    end
                end
            end
        end
        check(th, {name, " hs_o"}, nb[3], fa[3], fe[3]);
        check(tv, {name, " vs_o"}, nb[2], fa[2], fe[2]);
        check(tr, {name, " href_o"}, nb[1], fa[1], fe[1]);
        check(tf, {name, " field_o"}, nb[0], fa[0], fe[0]);
    endtask

    task automatic t_reset();
        pol_h = 1'b1; pol_v = 1'b1; pol_field = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs low while in reset, whatever the polarity bits
        check("R1", "reset hs_o", int'(hs_o !== 1'b0), hs_o, 1'b0);
        check("R1", "reset vs_o", int'(vs_o !== 1'b0), vs_o, 1'b0);
        check("R1", "reset href_o", int'(href_o !== 1'b0), href_o, 1'b0);
        check("R1", "reset field_o", int'(field_o !== 1'b0), field_o, 1'b0);
        pol_h = 1'b0; pol_v = 1'b0; pol_field = 1'b0;
    endtask

    task automatic t_ntsc_sync();
        pal_sel = 1'b0; out_mode = 2'b00; hs_begin = 10'd2; hs_end = 10'd6;
        run_scn("ntsc sync", "R3", "R4", "R7", "R8");
    endtask

    task automatic t_pal_active();
        pal_sel = 1'b1; out_mode = 2'b01; hs_begin = 10'd3; hs_end = 10'd9;
        run_scn("pal active", "R6", "R2", "R10", "R8");
    endtask

    task automatic t_inverted();
        pal_sel = 1'b0; out_mode = 2'b10; pol_h = 1'b1; pol_v = 1'b1; pol_field = 1'b1;
        run_scn("inverted", "R9", "R9", "R7", "R9");
        pol_h = 1'b0; pol_v = 1'b0; pol_field = 1'b0;
    endtask

    task automatic t_mode3();
        pal_sel = 1'b1; out_mode = 2'b11;
        run_scn("mode 11", "R5", "R5", "R7", "R8");
    endtask

    task automatic t_wrap();
        pal_sel = 1'b1; out_mode = 2'b00; hs_begin = 10'd20; hs_end = 10'd3;
        pol_v = 1'b1;
        run_scn("hs wrap", "R3", "R9", "R7", "R2");
        pol_v = 1'b0;
    endtask

    task automatic t_equal();
        pal_sel = 1'b0; out_mode = 2'b00; hs_begin = 10'd5; hs_end = 10'd5;
        run_scn("hs equal", "R3", "R4", "R10", "R8");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ntsc_sync();
        t_pal_active();
        t_inverted();
        t_mode3();
        t_wrap();
        t_equal();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule